// File: doc/BRIEF.md
# Time-Base Tap Interval and Watchdog Timer

This block watches a free-running time-base count supplied from outside and derives two timing services from it. The first is a fixed-interval tick: each time a chosen bit of the time base goes from 0 to 1, a sticky status flag is set, and an interrupt is raised while its enable is on. The second is a watchdog built on the same kind of tap. It escalates through three stages. The first expiry arms a pre-warning flag. The second expiry raises the watchdog status and its interrupt. A third expiry, while both are still pending, issues a one-cycle reset request of a software-chosen kind.

Each service picks its period by selecting one of four tap bits that are spaced four bits apart. Software keeps the watchdog quiet by clearing its flags with write-one pulses before the stages pile up. The time-base counter and the routing of the reset request are handled elsewhere.

Top module: `tbtap_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0.
- R2: The interval tap is time-base bit 17 + 4*`ivl_sel_i` (select 0..3 gives bits 17, 21, 25, 29). When that bit is 1 on a clock edge and was 0 on the edge before, `ivl_sts_o` is 1 after that edge. Falling edges and other bits leave it unchanged.
- R3: `ivl_irq_o` is registered. After each edge it equals the new `ivl_sts_o` ANDed with `ivl_ien_i` as sampled on that edge.
- R4: An edge is only counted when the same tap bit was 0 on the previous edge and is 1 now. Changing a select field onto a bit that is already 1 produces no event.
- R5: A 1 on `ivl_clr_i`, `wd_clr_arm_i` or `wd_clr_sts_i` clears the matching flag at the next edge. If an event that sets the flag arrives on the same edge, the flag ends up set.
- R6: The watchdog tap is time-base bit 21 + 4*`wd_sel_i` (bits 21, 25, 29, 33), with the same edge rule as R4.
- R7: A watchdog expiry with `wd_arm_o` clear (after any same-edge clear) sets `wd_arm_o` and changes nothing else.
- R8: An expiry with `wd_arm_o` set and `wd_sts_o` clear sets `wd_sts_o`. `wd_irq_o` equals the new `wd_sts_o` ANDed with `wd_ien_i`, registered the same way as in R3.
- R9: An expiry with both flags set and `wd_rkind_i` not 00 pulses `rst_req_o` high for one cycle and loads `rst_kind_o` with `wd_rkind_i`. The kind codes are 00 none, 01 core, 10 chip and 11 system. With kind 00 no pulse occurs. `rst_kind_o` holds its value until the next request.
- R10: Clearing `wd_arm_o` between two expiries keeps the second expiry at the first stage, so no interrupt and no reset follow.
- R11: The tap bits are sampled while reset is held. A tap bit that is already 1 when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | TB_W | Time-base value |
| ivl_sel_i | input | 2 | Interval tap select |
| ivl_ien_i | input | 1 | Interval interrupt enable |
| wd_sel_i | input | 2 | Watchdog tap select |
| wd_ien_i | input | 1 | Watchdog interrupt enable |
| wd_rkind_i | input | 2 | Reset kind for third expiry |
| ivl_clr_i | input | 1 | Clear interval status |
| wd_clr_arm_i | input | 1 | Clear watchdog arm flag |
| wd_clr_sts_i | input | 1 | Clear watchdog status |
| ivl_sts_o | output | 1 | Interval status flag |
| ivl_irq_o | output | 1 | Interval interrupt |
| wd_arm_o | output | 1 | Watchdog first-stage flag |
| wd_sts_o | output | 1 | Watchdog status flag |
| wd_irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_kind_o | output | 2 | Kind of the last reset request |

## Verification
Every result is due on the clock edge that first samples the stimulus. A tap bit that goes to 1 updates the flags, interrupts and reset request on that same edge. A clear pulse or an enable change also takes effect on the edge that samples it. The bench changes inputs on falling edges and advances a behavioural model on each rising edge. It compares every output at the next falling edge, exactly one edge after the stimulus. Scenario checks then confirm the tap positions, the escalation order and the clear races at those points.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_CORE = 2'b01,
    RK_CHIP = 2'b10,
    RK_SYS  = 2'b11
  } rst_kind_e;

  localparam int unsigned NTAP  = 4;
  localparam int unsigned SEL_W = $clog2(NTAP);
endpackage

// File: rtl/tbt_tap_edge.sv
module tbt_tap_edge #(
  parameter int unsigned TB_W  = 64,
  parameter int unsigned BASE  = 17,
  parameter int unsigned STEP  = 4,
  parameter int unsigned NTAP  = 4,
  localparam int unsigned SEL_W = $clog2(NTAP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             edge_o
);
  logic [NTAP-1:0] taps, taps_q, rise;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign taps[g] = tbase_i[BASE + g*STEP];
  end

  // Reset loads the live taps so a bit already high is not an edge.
  always_ff @(posedge clk) begin
    taps_q <= taps;
  end

  assign rise   = taps & ~taps_q;
  assign edge_o = rst ? 1'b0 : rise[sel_i];

  // R4: an edge means this very tap was low on the previous edge
  a_r4_same_bit_low: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (taps[sel_i] && !taps_q[sel_i]));
endmodule

// File: rtl/tbt_ivl.sv
module tbt_ivl (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_d;

  always_comb sts_d = (sts_o & ~clr_i) | event_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      sts_o <= sts_d;
      irq_o <= sts_d & ien_i;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    event_i |=> sts_o);
  a_r5_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !event_i) |=> !sts_o);
  a_r3_irq_needs_sts: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> sts_o);
endmodule

// File: rtl/tbt_wdog.sv
module tbt_wdog
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expire_i,
  input  logic       clr_arm_i,
  input  logic       clr_sts_i,
  input  logic       ien_i,
  input  logic [1:0] rkind_i,
  output logic       arm_o,
  output logic       sts_o,
  output logic       irq_o,
  output logic       req_o,
  output logic [1:0] kind_o
);
  logic arm_eff, sts_eff, arm_d, sts_d, fire;

  always_comb begin
    arm_eff = arm_o & ~clr_arm_i;
    sts_eff = sts_o & ~clr_sts_i;
    arm_d   = arm_eff | expire_i;
    sts_d   = sts_eff | (expire_i & arm_eff);
    fire    = expire_i & arm_eff & sts_eff & (rkind_i != RK_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_o  <= 1'b0;
      sts_o  <= 1'b0;
      irq_o  <= 1'b0;
      req_o  <= 1'b0;
      kind_o <= RK_NONE;
    end else begin
      arm_o <= arm_d;
      sts_o <= sts_d;
      irq_o <= sts_d & ien_i;
      req_o <= fire;
      if (fire) kind_o <= rkind_i;
    end
  end

  a_r8_sts_after_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_o) |-> arm_o);
  a_r9_req_has_kind: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (kind_o != RK_NONE));
  a_r9_req_from_full: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (arm_o && sts_o));
  a_r9_kind_stable: assert property (@(posedge clk) disable iff (rst)
    !req_o |-> $stable(kind_o));
  a_r10_cleared_arm_no_sts: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !arm_o && !sts_o) |=> !sts_o && !req_o);
endmodule

// File: rtl/tbtap_timer.sv
module tbtap_timer
  import tbt_pkg::*;
#(
  parameter int unsigned TB_W     = 64,
  parameter int unsigned IVL_BASE = 17,
  parameter int unsigned WD_BASE  = 21,
  parameter int unsigned TAP_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tbase_i,
  input  logic [1:0]      ivl_sel_i,
  input  logic            ivl_ien_i,
  input  logic [1:0]      wd_sel_i,
  input  logic            wd_ien_i,
  input  logic [1:0]      wd_rkind_i,
  input  logic            ivl_clr_i,
  input  logic            wd_clr_arm_i,
  input  logic            wd_clr_sts_i,
  output logic            ivl_sts_o,
  output logic            ivl_irq_o,
  output logic            wd_arm_o,
  output logic            wd_sts_o,
  output logic            wd_irq_o,
  output logic            rst_req_o,
  output logic [1:0]      rst_kind_o
);
  logic ivl_evt, wd_evt;

  tbt_tap_edge #(.TB_W(TB_W), .BASE(IVL_BASE), .STEP(TAP_STEP), .NTAP(NTAP)) u_ivl_tap (
    .clk(clk), .rst(rst), .tbase_i(tbase_i), .sel_i(ivl_sel_i), .edge_o(ivl_evt)
  );

  tbt_tap_edge #(.TB_W(TB_W), .BASE(WD_BASE), .STEP(TAP_STEP), .NTAP(NTAP)) u_wd_tap (
    .clk(clk), .rst(rst), .tbase_i(tbase_i), .sel_i(wd_sel_i), .edge_o(wd_evt)
  );

  tbt_ivl u_ivl (
    .clk(clk), .rst(rst), .event_i(ivl_evt), .clr_i(ivl_clr_i), .ien_i(ivl_ien_i),
    .sts_o(ivl_sts_o), .irq_o(ivl_irq_o)
  );

  tbt_wdog u_wdog (
    .clk(clk), .rst(rst), .expire_i(wd_evt), .clr_arm_i(wd_clr_arm_i),
    .clr_sts_i(wd_clr_sts_i), .ien_i(wd_ien_i), .rkind_i(wd_rkind_i),
    .arm_o(wd_arm_o), .sts_o(wd_sts_o), .irq_o(wd_irq_o),
    .req_o(rst_req_o), .kind_o(rst_kind_o)
  );

  // R1: first cycle out of reset shows a clean state
  a_r1_clean_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !ivl_sts_o && !wd_arm_o && !wd_sts_o && !rst_req_o && rst_kind_o == 2'b00);
endmodule

// File: tb/tbtap_timer_bench.sv
module tbtap_timer_bench;
  localparam int TB_W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TB_W-1:0] tbv = '1;
  logic [1:0] ivl_sel = 2'd0, wd_sel = 2'd3, rkind = 2'd0;
  logic ivl_ien = 1'b0, wd_ien = 1'b0;
  logic ivl_clr = 1'b0, clr_arm = 1'b0, clr_sts = 1'b0;
  logic ivl_sts, ivl_irq, wd_arm, wd_sts, wd_irq, rreq;
  logic [1:0] rkind_o;

  int total = 0;
  int bad = 0;

  // behavioural model state
  logic [TB_W-1:0] m_prev;
  bit m_ists, m_iirq, m_arm, m_wsts, m_wirq, m_req;
  bit [1:0] m_kind;

  always #5 clk = ~clk;

  tbtap_timer u_tbtap_timer (
    .clk(clk), .rst(rst), .tbase_i(tbv), .ivl_sel_i(ivl_sel), .ivl_ien_i(ivl_ien),
    .wd_sel_i(wd_sel), .wd_ien_i(wd_ien), .wd_rkind_i(rkind), .ivl_clr_i(ivl_clr),
    .wd_clr_arm_i(clr_arm), .wd_clr_sts_i(clr_sts), .ivl_sts_o(ivl_sts),
    .ivl_irq_o(ivl_irq), .wd_arm_o(wd_arm), .wd_sts_o(wd_sts), .wd_irq_o(wd_irq),
    .rst_req_o(rreq), .rst_kind_o(rkind_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ib, wb;
    bit ie, we, a, s;
    if (rst) begin
      m_prev = tbv;
      {m_ists, m_iirq, m_arm, m_wsts, m_wirq, m_req} = '0;
      m_kind = 2'd0;
      return;
    end
    ib = 17 + 4 * int'(ivl_sel);
    wb = 21 + 4 * int'(wd_sel);
    ie = tbv[ib] && !m_prev[ib];
    we = tbv[wb] && !m_prev[wb];
    m_ists = (m_ists && !ivl_clr) || ie;
    m_iirq = m_ists && ivl_ien;
    a = m_arm && !clr_arm;
    s = m_wsts && !clr_sts;
    m_req = 1'b0;
    if (we) begin
      if (!a) a = 1'b1;
      else if (!s) s = 1'b1;
      else if (rkind != 2'd0) begin
        m_req = 1'b1;
        m_kind = rkind;
      end
    end
    m_arm = a;
    m_wsts = s;
    m_wirq = s && wd_ien;
    m_prev = tbv;
  endtask

  // one clock: model follows the rising edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 ivl_sts", ivl_sts, m_ists);
    chk("R3 ivl_irq", ivl_irq, m_iirq);
    chk("R7 wd_arm", wd_arm, m_arm);
    chk("R8 wd_sts", wd_sts, m_wsts);
    chk("R8 wd_irq", wd_irq, m_wirq);
    chk("R9 rst_req", rreq, m_req);
    chk("R9 rst_kind", rkind_o, m_kind);
  endtask

  task automatic rise(input int pos);
    tbv[pos] = 1'b0;
    tick();
    tbv[pos] = 1'b1;
    tick();
  endtask

  task automatic pulse_clr_ivl();
    ivl_clr = 1'b1;
    tick();
    ivl_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired before the bench completed");
    finish_run();
  end

  initial begin
    tick();
    tick();
    chk("R1 reset ivl_sts", ivl_sts, 0);
    chk("R1 reset rst_req", rreq, 0);
    chk("R1 reset rst_kind", rkind_o, 0);
    rst = 1'b0;
    tick();
    tick();
    // every tap is already high at release
    chk("R11 no edge from high tap", ivl_sts, 0);
    chk("R11 no watchdog edge", wd_arm, 0);
    tbv = '0;
    tick();

    // interval tap positions
    for (int s = 0; s < 4; s++) begin
      ivl_sel = 2'(s);
      rise(17 + 4 * ((s + 1) % 4));
      chk("R2 other bit ignored", ivl_sts, 0);
      rise(17 + 4 * s);
      chk("R2 selected tap sets", ivl_sts, 1);
      tbv[17 + 4 * s] = 1'b0;
      tick();
      chk("R2 falling edge keeps", ivl_sts, 1);
      pulse_clr_ivl();
      tick();
      chk("R5 clear", ivl_sts, 0);
    end

    // interrupt enable
    ivl_sel = 2'd0;
    ivl_ien = 1'b1;
    rise(17);
    chk("R3 irq with enable", ivl_irq, 1);
    ivl_ien = 1'b0;
    tick();
    chk("R3 irq follows enable", ivl_irq, 0);
    chk("R3 status kept", ivl_sts, 1);
    pulse_clr_ivl();

    // select change onto a high bit
    tbv[17] = 1'b1;
    tbv[21] = 1'b0;
    ivl_sel = 2'd1;
    tick();
    tick();
    ivl_sel = 2'd0;
    tick();
    chk("R4 select change no edge", ivl_sts, 0);

    // clear racing an event
    tbv[17] = 1'b0;
    tick();
    tbv[17] = 1'b1;
    ivl_clr = 1'b1;
    tick();
    ivl_clr = 1'b0;
    chk("R5 event beats clear", ivl_sts, 1);
    pulse_clr_ivl();

    // watchdog escalation
    ivl_sel = 2'd3;
    wd_sel = 2'd0;
    wd_ien = 1'b1;
    rkind = 2'd2;
    rise(21);
    chk("R7 first expiry arms", wd_arm, 1);
    chk("R7 first expiry no sts", wd_sts, 0);
    rise(21);
    chk("R8 second expiry sts", wd_sts, 1);
    chk("R8 irq raised", wd_irq, 1);
    wd_ien = 1'b0;
    tick();
    chk("R8 irq gated", wd_irq, 0);
    rise(21);
    chk("R9 reset pulse", rreq, 1);
    chk("R9 kind chip", rkind_o, 2);
    tick();
    chk("R9 pulse one cycle", rreq, 0);
    chk("R9 kind held", rkind_o, 2);
    rkind = 2'd0;
    rise(21);
    chk("R9 kind none no pulse", rreq, 0);
    chk("R9 kind unchanged", rkind_o, 2);
    rkind = 2'd3;
    rise(21);
    chk("R9 system kind", rkind_o, 3);

    // service between expiries
    clr_arm = 1'b1;
    clr_sts = 1'b1;
    tick();
    clr_arm = 1'b0;
    clr_sts = 1'b0;
    chk("R5 wd flags cleared", wd_arm, 0);
    rise(21);
    chk("R10 first stage again", wd_arm, 1);
    clr_arm = 1'b1;
    tick();
    clr_arm = 1'b0;
    rise(21);
    chk("R10 no status after service", wd_sts, 0);
    chk("R10 no reset after service", rreq, 0);
    clr_arm = 1'b1;
    tick();
    clr_arm = 1'b0;

    // watchdog tap positions
    for (int s = 0; s < 4; s++) begin
      wd_sel = 2'(s);
      rise(21 + 4 * ((s + 3) % 4));
      chk("R6 other bit ignored", wd_arm, 0);
      rise(21 + 4 * s);
      chk("R6 selected tap arms", wd_arm, 1);
      clr_arm = 1'b1;
      tick();
      clr_arm = 1'b0;
    end

    tick();
    finish_run();
  end
endmodule